// File: doc/BRIEF.md
# Dimension-Ordered Mesh Route Selector

This block makes the output-port decision for one input of a two-dimensional mesh router that forwards packets as wormholes. It compares the node's own coordinates with the destination coordinates carried in a packet's first flit. It then names one of five outputs: east (+X), west (-X), north (+Y), south (-Y), or the local ejection port. Every hop along X is taken before any hop along Y. Because routing follows this fixed order, no cycle can form among channel dependencies, and wormhole traffic cannot deadlock. The cost is that the path is fixed: packets leaving several sources toward a common corner have no choice of path and contend for the same links.

A packet can be longer than any buffer it passes through, so the decision belongs to the whole packet. The first flit computes the port and the block latches it. Body and tail flits reuse the latched port and ignore their own destination bits. The latch is released when the tail flit is accepted. A flit that is both first and last is routed on its own and leaves nothing latched.

Top module: `dor_route_unit`

## Requirements
- R1: If the destination X differs from the node X (both unsigned), the port is +X (code 1) when destination X is larger and -X (code 2) when it is smaller, whatever the Y values are.
- R2: If the X values are equal and the Y values differ, the port is +Y (code 3) when destination Y is larger and -Y (code 4) when it is smaller.
- R3: If both coordinate pairs are equal, the port is local (code 0).
- R4: A valid flit of kind head (2'b01) or single (2'b11) drives `port_valid` high in the same cycle, and `port_sel` carries the decision taken from that flit's own destination fields.
- R5: A valid body (2'b00) or tail (2'b10) flit inside an open packet gets `port_valid` high and the port latched by the packet's head. Its own destination fields, and any change of the node coordinates after the head, have no effect.
- R6: Accepting a tail closes the packet. Later body or tail flits get `port_valid` low until a new head arrives.
- R7: A single flit opens no packet. A body flit after it gets `port_valid` low.
- R8: After synchronous reset, no packet is open. A body flit gets `port_valid` low, and `port_valid` is low while `flit_valid` is low.
- R9: Cycles with `flit_valid` low give `port_valid` low and leave the latched route and open state unchanged.
- R10: A head that arrives while a packet is open starts a new packet and replaces the latched port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flit_valid | input | 1 | A flit is presented and accepted this cycle |
| flit_kind | input | 2 | 00 body, 01 head, 10 tail, 11 single |
| flit_dst_x | input | COORD_W | Destination X field of the flit |
| flit_dst_y | input | COORD_W | Destination Y field of the flit |
| node_x | input | COORD_W | This router's X coordinate |
| node_y | input | COORD_W | This router's Y coordinate |
| port_valid | output | 1 | `port_sel` applies to the presented flit |
| port_sel | output | 3 | 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |

## Verification
The bench builds the block with the default coordinate width of 4, so it can drive coordinates 0 and 15 at both ends of each axis. This covers the largest positive and negative offsets and the corner-to-corner paths that dimension ordering forces onto shared links. With this narrow width, one table of vectors reaches every branch of the decision. Directed sequences then exercise how the latch opens, holds, is replaced and is released across packet boundaries.

// File: rtl/dor_route_pkg.sv
package dor_route_pkg;

    typedef enum logic [1:0] {
        FK_BODY   = 2'b00,
        FK_HEAD   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_XNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_YNEG  = 3'd4
    } route_port_e;

    localparam int unsigned NUM_AXES = 2;

    function automatic logic starts_packet(flit_kind_e k);
        return (k == FK_HEAD) || (k == FK_SINGLE);
    endfunction

    function automatic logic ends_packet(flit_kind_e k);
        return (k == FK_TAIL) || (k == FK_SINGLE);
    endfunction

endpackage

// File: rtl/dor_axis_cmp.sv
module dor_axis_cmp #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output logic         ahead,
    output logic         behind
);
    assign ahead  = dst > cur;
    assign behind = dst < cur;
endmodule

// File: rtl/dor_decide.sv
module dor_decide
    import dor_route_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] cur_x,
    input  logic [W-1:0] cur_y,
    input  logic [W-1:0] dst_x,
    input  logic [W-1:0] dst_y,
    output route_port_e  port
);
    logic [W-1:0]          cur_a [NUM_AXES];
    logic [W-1:0]          dst_a [NUM_AXES];
    logic [NUM_AXES-1:0]   ahead;
    logic [NUM_AXES-1:0]   behind;

    assign cur_a[0] = cur_x;
    assign cur_a[1] = cur_y;
    assign dst_a[0] = dst_x;
    assign dst_a[1] = dst_y;

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        dor_axis_cmp #(.W(W)) cmp_i (
            .cur    (cur_a[g]),
            .dst    (dst_a[g]),
            .ahead  (ahead[g]),
            .behind (behind[g])
        );
    end

    // Lower dimension (X, axis 0) has priority over Y.
    always_comb begin
        if (ahead[0])       port = PORT_XPOS;
        else if (behind[0]) port = PORT_XNEG;
        else if (ahead[1])  port = PORT_YPOS;
        else if (behind[1]) port = PORT_YNEG;
        else                port = PORT_LOCAL;
    end

    always_comb begin
        if (ahead[0] || behind[0])
            p_x_before_y_r1: assert (port == PORT_XPOS || port == PORT_XNEG);
        if (!ahead[0] && !behind[0] && (ahead[1] || behind[1]))
            p_y_after_x_r2: assert (port == PORT_YPOS || port == PORT_YNEG);
    end

endmodule

// File: rtl/dor_hold.sv
module dor_hold
    import dor_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take_head,
    input  logic        take_single,
    input  logic        take_tail,
    input  route_port_e new_port,
    output logic        open_q,
    output route_port_e held_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            held_q <= PORT_LOCAL;
        end else if (take_head) begin
            held_q <= new_port;
            open_q <= !take_single;
        end else if (take_tail) begin
            open_q <= 1'b0;
        end
    end

    p_single_no_open_r7: assert property (@(posedge clk) disable iff (rst)
        take_single |=> !open_q);

    p_tail_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (take_tail && !take_head) |=> !open_q);

    p_hold_route_r5: assert property (@(posedge clk) disable iff (rst)
        !take_head |=> $stable(held_q));

    p_head_loads_r10: assert property (@(posedge clk) disable iff (rst)
        take_head |=> (held_q == $past(new_port)));

endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
    import dor_route_pkg::*;
#(
    parameter int unsigned COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flit_valid,
    input  logic [1:0]         flit_kind,
    input  logic [COORD_W-1:0] flit_dst_x,
    input  logic [COORD_W-1:0] flit_dst_y,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    output logic               port_valid,
    output logic [2:0]         port_sel
);
    flit_kind_e  kind;
    route_port_e decided;
    route_port_e held;
    logic        open_q;
    logic        is_first;

    assign kind     = flit_kind_e'(flit_kind);
    assign is_first = starts_packet(kind);

    dor_decide #(.W(COORD_W)) decide_i (
        .cur_x (node_x),
        .cur_y (node_y),
        .dst_x (flit_dst_x),
        .dst_y (flit_dst_y),
        .port  (decided)
    );

    dor_hold hold_i (
        .clk         (clk),
        .rst         (rst),
        .take_head   (flit_valid && is_first),
        .take_single (flit_valid && kind == FK_SINGLE),
        .take_tail   (flit_valid && ends_packet(kind)),
        .new_port    (decided),
        .open_q      (open_q),
        .held_q      (held)
    );

    assign port_sel   = is_first ? decided : held;
    assign port_valid = flit_valid && (is_first || open_q);

    p_follow_needs_open_r6: assert property (@(posedge clk) disable iff (rst)
        (port_valid && !is_first) |-> open_q);

    p_follow_uses_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (port_valid && !is_first) |-> (port_sel == 3'(held)));

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !open_q);

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        !flit_valid |=> (open_q == $past(open_q)));

endmodule

// File: tb/dor_route_unit_tb_top.sv
module dor_route_unit_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flit_valid = 1'b0;
    logic [1:0]   flit_kind = 2'b00;
    logic [W-1:0] flit_dst_x = '0;
    logic [W-1:0] flit_dst_y = '0;
    logic [W-1:0] node_x = '0;
    logic [W-1:0] node_y = '0;
    logic         port_valid;
    logic [2:0]   port_sel;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dor_route_unit #(.COORD_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .flit_valid (flit_valid),
        .flit_kind  (flit_kind),
        .flit_dst_x (flit_dst_x),
        .flit_dst_y (flit_dst_y),
        .node_x     (node_x),
        .node_y     (node_y),
        .port_valid (port_valid),
        .port_sel   (port_sel)
    );

    // {node_x, node_y, dst_x, dst_y, expected port}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {4'd3,  4'd3,  4'd7,  4'd3,  3'd1},
        {4'd7,  4'd3,  4'd3,  4'd3,  3'd2},
        {4'd0,  4'd0,  4'd3,  4'd3,  3'd1},
        {4'd3,  4'd0,  4'd3,  4'd3,  3'd3},
        {4'd3,  4'd3,  4'd3,  4'd0,  3'd4},
        {4'd6,  4'd6,  4'd6,  4'd6,  3'd0},
        {4'd0,  4'd0,  4'd15, 4'd15, 3'd1},
        {4'd15, 4'd15, 4'd0,  4'd0,  3'd2},
        {4'd15, 4'd0,  4'd15, 4'd15, 3'd3},
        {4'd0,  4'd15, 4'd0,  4'd0,  3'd4},
        {4'd1,  4'd0,  4'd3,  4'd2,  3'd1},
        {4'd0,  4'd0,  4'd0,  4'd0,  3'd0},
        {4'd15, 4'd15, 4'd15, 4'd15, 3'd0},
        {4'd8,  4'd2,  4'd7,  4'd14, 3'd2}
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one flit after a falling edge and sample before the next rise.
    task automatic put(input logic v, input logic [1:0] k, input logic [W-1:0] dx, input logic [W-1:0] dy);
        @(negedge clk);
        flit_valid = v;
        flit_kind  = k;
        flit_dst_x = dx;
        flit_dst_y = dy;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        flit_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        chk("R8 idle after reset", {3'd0, port_valid}, 4'd0);
        put(1'b1, 2'b00, 4'd1, 4'd1);
        chk("R8 body after reset", {3'd0, port_valid}, 4'd0);

        // Table walk: kind alternates single / head (R4)
        for (int i = 0; i < NV; i++) begin
            logic [2:0] ex;
            string      tag;
            ex = VEC[i][2:0];
            tag = (ex == 3'd0) ? "R3" : (ex <= 3'd2) ? "R1" : "R2";
            node_x = VEC[i][18:15];
            node_y = VEC[i][14:11];
            put(1'b1, (i % 2 == 0) ? 2'b11 : 2'b01, VEC[i][10:7], VEC[i][6:3]);
            chk({tag, " R4 valid"}, {3'd0, port_valid}, 4'd1);
            chk({tag, " port"}, {1'b0, port_sel}, {1'b0, ex});
        end

        // Packet latch: head at (5,5) to (9,2) -> +X
        do_reset();
        node_x = 4'd5; node_y = 4'd5;
        put(1'b1, 2'b01, 4'd9, 4'd2);
        chk("R4 head port", {1'b0, port_sel}, 4'd1);
        put(1'b1, 2'b00, 4'd0, 4'd0);
        chk("R5 body valid", {3'd0, port_valid}, 4'd1);
        chk("R5 body ignores dest", {1'b0, port_sel}, 4'd1);
        node_x = 4'd12;
        put(1'b1, 2'b00, 4'd12, 4'd5);
        chk("R5 body ignores node move", {1'b0, port_sel}, 4'd1);
        put(1'b1, 2'b10, 4'd0, 4'd15);
        chk("R5 tail valid", {3'd0, port_valid}, 4'd1);
        chk("R5 tail port", {1'b0, port_sel}, 4'd1);
        put(1'b1, 2'b00, 4'd9, 4'd2);
        chk("R6 body after tail", {3'd0, port_valid}, 4'd0);
        put(1'b1, 2'b10, 4'd9, 4'd2);
        chk("R6 tail after tail", {3'd0, port_valid}, 4'd0);

        // Idle gaps keep the route: head to (5,1) from (5,5) -> -Y
        node_x = 4'd5;
        put(1'b1, 2'b01, 4'd5, 4'd1);
        chk("R2 head -Y", {1'b0, port_sel}, 4'd4);
        put(1'b0, 2'b00, 4'd0, 4'd0);
        chk("R9 idle no valid", {3'd0, port_valid}, 4'd0);
        put(1'b0, 2'b10, 4'd0, 4'd0);
        chk("R9 idle tail no valid", {3'd0, port_valid}, 4'd0);
        put(1'b1, 2'b00, 4'd15, 4'd15);
        chk("R9 body after idle valid", {3'd0, port_valid}, 4'd1);
        chk("R9 body after idle port", {1'b0, port_sel}, 4'd4);

        // New head while open replaces the route: (2,5) -> -X
        put(1'b1, 2'b01, 4'd2, 4'd5);
        chk("R10 new head port", {1'b0, port_sel}, 4'd2);
        put(1'b1, 2'b00, 4'd5, 4'd9);
        chk("R10 body follows new head", {1'b0, port_sel}, 4'd2);
        put(1'b1, 2'b10, 4'd5, 4'd9);
        chk("R10 tail follows new head", {1'b0, port_sel}, 4'd2);

        // Single flit opens nothing
        put(1'b1, 2'b11, 4'd5, 4'd9);
        chk("R7 single port", {1'b0, port_sel}, 4'd3);
        put(1'b1, 2'b00, 4'd5, 4'd9);
        chk("R7 body after single", {3'd0, port_valid}, 4'd0);

        // Reset drops an open packet
        put(1'b1, 2'b01, 4'd9, 4'd9);
        chk("R4 head before reset", {3'd0, port_valid}, 4'd1);
        do_reset();
        put(1'b1, 2'b00, 4'd9, 4'd9);
        chk("R8 body after mid-packet reset", {3'd0, port_valid}, 4'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule